// File: doc/BRIEF.md
# Dual Mailbox Register Pair

This block holds two 32-bit mailboxes that pass messages between a host processor and a DSP. One mailbox (the DSP mailbox) carries mail from the DSP towards the host. The other (the CPU mailbox) carries mail from the host towards the DSP. Each mailbox is stored as a high and a low 16-bit half. Bit 15 of the high half is not data: it is a full flag, and it is mirrored on a level output for polling or for raising an interrupt.

The DSP reaches the mailboxes through its memory-mapped I/O window, using an 8-bit offset. Offsets in that window that do not belong to a mailbox fall through to a generic register file of 2^ADDR_W words. A write to the DMA-start offset also fires a one-cycle strobe. The host has a 2-bit port that reaches the four mailbox halves directly. Writing a low half marks its mailbox full. Reading a low half, from either side, marks it empty. Reads return data in the same cycle. Every state change takes effect at the next rising clock edge.

Top module: `dual_mailbox`

## Requirements
- R1: After reset, every mailbox half reads 0x0000, both full outputs are low, dma_start is low and every generic register reads 0x0000.
- R2: A DSP write to offset 0xFC stores the DSP mailbox high half (bits 14:0). A DSP write to 0xFD stores its low half and sets its full flag. A read of 0xFC returns {flag, stored bits 14:0}.
- R3: A write to a high half stores only bits 14:0. The full flag of that mailbox keeps its value.
- R4: Reading a low half (DSP offset 0xFD/0xFF or host address 1/3 with its read strobe) returns the stored word and clears that mailbox's flag at the next edge. Reading a high half leaves the flag unchanged.
- R5: Host address encoding: 0 = DSP mailbox high, 1 = DSP mailbox low, 2 = CPU mailbox high, 3 = CPU mailbox low. DSP offsets 0xFE/0xFF reach the same CPU mailbox storage as host addresses 2/3.
- R6: When a low half of a mailbox is written and read in the same cycle, the write wins and the flag ends set.
- R7: When both sides write the same half in the same cycle, the DSP-side data is stored (default priority).
- R8: A DSP write to offset 0xCB stores the value in the generic file. It also drives dma_start high for exactly the following cycle, once per write.
- R9: A DSP write to any offset other than 0xFC–0xFF goes to the generic register file at that offset. The value reads back at that offset and leaves both mailboxes unchanged.
- R10: dsp_mail_full and cpu_mail_full always equal bit 15 of the DSP and CPU mailbox high halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_addr | input | ADDR_W | DSP I/O offset |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_rd | input | 1 | DSP read strobe (side effects only) |
| dsp_wdata | input | DATA_W | DSP write data |
| dsp_rdata | output | DATA_W | DSP read data, combinational |
| host_addr | input | 2 | Host mailbox half select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects only) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational |
| dma_start | output | 1 | One-cycle DMA-start pulse |
| dsp_mail_full | output | 1 | DSP mailbox full flag level |
| cpu_mail_full | output | 1 | CPU mailbox full flag level |

## Verification
Read data is due in the same cycle as the address. The bench therefore samples both read buses 1 ns after driving a step, before the rising edge that would apply that step's side effects. Flag changes, stored data and the DMA strobe are due one edge after the access. They are compared at the following falling edge against a behavioural model updated at that edge. This catches an off-by-one cycle in either direction, including the same-cycle write/read and write/write collisions.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned MBX_COUNT = 2;

   typedef enum logic {
      MBX_DSP = 1'b0,
      MBX_CPU = 1'b1
   } mbx_id_e;

   typedef struct packed {
      logic wr_hi;
      logic wr_lo;
      logic rd_lo;
   } mbx_acc_t;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
(
   input  logic                       hit,
   input  logic                       wr,
   input  logic                       rd,
   input  logic [1:0]                 sel,
   output mbx_acc_t [MBX_COUNT-1:0]   acc
);
   for (genvar m = 0; m < MBX_COUNT; m++) begin : g_box
      logic this_box;
      assign this_box     = hit && (int'(sel[1]) == m);
      assign acc[m].wr_hi = this_box && wr && !sel[0];
      assign acc[m].wr_lo = this_box && wr &&  sel[0];
      assign acc[m].rd_lo = this_box && rd &&  sel[0];
   end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter bit          DSP_PRIORITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mbx_acc_t          dsp_acc,
   input  mbx_acc_t          host_acc,
   input  logic [DATA_W-1:0] dsp_wdata,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] hi_rd,
   output logic [DATA_W-1:0] lo_rd,
   output logic              full
);
   localparam int unsigned HI_W = DATA_W - 1;

   logic [HI_W-1:0]   hi_q, hi_src;
   logic [DATA_W-1:0] lo_q, lo_src;
   logic              flag_q;
   logic              any_wr_hi, any_wr_lo, any_rd_lo;

   assign any_wr_hi = dsp_acc.wr_hi || host_acc.wr_hi;
   assign any_wr_lo = dsp_acc.wr_lo || host_acc.wr_lo;
   assign any_rd_lo = dsp_acc.rd_lo || host_acc.rd_lo;

   if (DSP_PRIORITY) begin : g_dsp_first
      assign hi_src = dsp_acc.wr_hi ? dsp_wdata[HI_W-1:0] : host_wdata[HI_W-1:0];
      assign lo_src = dsp_acc.wr_lo ? dsp_wdata : host_wdata;
   end else begin : g_host_first
      assign hi_src = host_acc.wr_hi ? host_wdata[HI_W-1:0] : dsp_wdata[HI_W-1:0];
      assign lo_src = host_acc.wr_lo ? host_wdata : dsp_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         flag_q <= 1'b0;
      end else begin
         if (any_wr_hi) hi_q <= hi_src;
         if (any_wr_lo) lo_q <= lo_src;
         if (any_wr_lo)      flag_q <= 1'b1;
         else if (any_rd_lo) flag_q <= 1'b0;
      end
   end

   assign hi_rd = {flag_q, hi_q};
   assign lo_rd = lo_q;
   assign full  = flag_q;
endmodule

// File: rtl/mbx_genfile.sv
module mbx_genfile #(
   parameter int unsigned          DATA_W  = 16,
   parameter int unsigned          ADDR_W  = 8,
   parameter logic [ADDR_W-1:0]    DMA_OFS = 8'hCB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              dma_start
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] regs_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
         dma_start <= 1'b0;
      end else begin
         dma_start <= wr && (addr == DMA_OFS);
         if (wr) regs_q[addr] <= wdata;
      end
   end

   assign rdata = regs_q[addr];
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned          DATA_W       = 16,
   parameter int unsigned          ADDR_W       = 8,
   parameter logic [ADDR_W-1:0]    MBX_BASE     = 8'hFC,
   parameter logic [ADDR_W-1:0]    DMA_OFS      = 8'hCB,
   parameter bit                   DSP_PRIORITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] dsp_addr,
   input  logic              dsp_wr,
   input  logic              dsp_rd,
   input  logic [DATA_W-1:0] dsp_wdata,
   output logic [DATA_W-1:0] dsp_rdata,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              dma_start,
   output logic              dsp_mail_full,
   output logic              cpu_mail_full
);
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must leave room for a flag bit");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small for the mailbox window");
   end
   if (MBX_BASE[1:0] != 2'b00) begin : g_bad_base
      $error("MBX_BASE must be aligned to four");
   end
   if (DMA_OFS[ADDR_W-1:2] == MBX_BASE[ADDR_W-1:2]) begin : g_bad_dma
      $error("DMA_OFS overlaps the mailbox window");
   end

   logic                        dsp_hit;
   mbx_acc_t [MBX_COUNT-1:0]    dsp_acc, host_acc;
   logic [DATA_W-1:0]           slot_hi [MBX_COUNT];
   logic [DATA_W-1:0]           slot_lo [MBX_COUNT];
   logic [MBX_COUNT-1:0]        slot_full;
   logic [DATA_W-1:0]           gen_rdata;

   assign dsp_hit = (dsp_addr[ADDR_W-1:2] == MBX_BASE[ADDR_W-1:2]);

   mbx_port_dec i_dsp_dec (
      .hit (dsp_hit),
      .wr  (dsp_wr),
      .rd  (dsp_rd),
      .sel (dsp_addr[1:0]),
      .acc (dsp_acc)
   );

   mbx_port_dec i_host_dec (
      .hit (1'b1),
      .wr  (host_wr),
      .rd  (host_rd),
      .sel (host_addr),
      .acc (host_acc)
   );

   for (genvar m = 0; m < MBX_COUNT; m++) begin : g_slot
      mbx_slot #(
         .DATA_W       (DATA_W),
         .DSP_PRIORITY (DSP_PRIORITY)
      ) i_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .dsp_acc    (dsp_acc[m]),
         .host_acc   (host_acc[m]),
         .dsp_wdata  (dsp_wdata),
         .host_wdata (host_wdata),
         .hi_rd      (slot_hi[m]),
         .lo_rd      (slot_lo[m]),
         .full       (slot_full[m])
      );
   end

   mbx_genfile #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .DMA_OFS (DMA_OFS)
   ) i_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (dsp_wr && !dsp_hit),
      .addr      (dsp_addr),
      .wdata     (dsp_wdata),
      .rdata     (gen_rdata),
      .dma_start (dma_start)
   );

   always_comb begin
      if (dsp_hit)
         dsp_rdata = dsp_addr[0] ? slot_lo[dsp_addr[1]] : slot_hi[dsp_addr[1]];
      else
         dsp_rdata = gen_rdata;
      host_rdata = host_addr[0] ? slot_lo[host_addr[1]] : slot_hi[host_addr[1]];
   end

   assign dsp_mail_full = slot_full[MBX_DSP];
   assign cpu_mail_full = slot_full[MBX_CPU];
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
   parameter int unsigned       ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] MBX_BASE = 8'hFC,
   parameter logic [ADDR_W-1:0] DMA_OFS  = 8'hCB
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] dsp_addr,
   input logic              dsp_wr,
   input logic              dsp_rd,
   input logic [1:0]        host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic              dsp_rd_msb,
   input logic              host_rd_msb,
   input logic              dma_start,
   input logic              dsp_mail_full,
   input logic              cpu_mail_full
);
   logic dsp_box_lo_wr, dsp_box_lo_rd, cpu_box_lo_wr, cpu_box_lo_rd, cpu_box_hi_wr;

   assign dsp_box_lo_wr = (dsp_wr && dsp_addr == MBX_BASE + 1) || (host_wr && host_addr == 2'd1);
   assign dsp_box_lo_rd = (dsp_rd && dsp_addr == MBX_BASE + 1) || (host_rd && host_addr == 2'd1);
   assign cpu_box_lo_wr = (dsp_wr && dsp_addr == MBX_BASE + 3) || (host_wr && host_addr == 2'd3);
   assign cpu_box_lo_rd = (dsp_rd && dsp_addr == MBX_BASE + 3) || (host_rd && host_addr == 2'd3);
   assign cpu_box_hi_wr = (dsp_wr && dsp_addr == MBX_BASE + 2) || (host_wr && host_addr == 2'd2);

   // R2
   dsp_lo_wr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_box_lo_wr |=> dsp_mail_full);

   // R5
   cpu_lo_wr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_box_lo_wr |=> cpu_mail_full);

   // R4
   dsp_lo_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_box_lo_rd && !dsp_box_lo_wr) |=> !dsp_mail_full);

   // R3
   cpu_hi_wr_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_box_hi_wr && !cpu_box_lo_wr && !cpu_box_lo_rd) |=> $stable(cpu_mail_full));

   // R6
   cpu_wr_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_box_lo_wr && cpu_box_lo_rd) |=> cpu_mail_full);

   // R8
   dma_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_wr && dsp_addr == DMA_OFS) |=> dma_start);

   // R8
   dma_only_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |-> $past(dsp_wr && dsp_addr == DMA_OFS));

   // R10
   dsp_full_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsp_addr == MBX_BASE) |-> (dsp_rd_msb == dsp_mail_full));

   // R10
   cpu_full_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == 2'd2) |-> (host_rd_msb == cpu_mail_full));
endmodule

bind dual_mailbox mbx_chk #(
   .ADDR_W   (ADDR_W),
   .MBX_BASE (MBX_BASE),
   .DMA_OFS  (DMA_OFS)
) i_mbx_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .dsp_addr      (dsp_addr),
   .dsp_wr        (dsp_wr),
   .dsp_rd        (dsp_rd),
   .host_addr     (host_addr),
   .host_wr       (host_wr),
   .host_rd       (host_rd),
   .dsp_rd_msb    (dsp_rdata[DATA_W-1]),
   .host_rd_msb   (host_rdata[DATA_W-1]),
   .dma_start     (dma_start),
   .dsp_mail_full (dsp_mail_full),
   .cpu_mail_full (cpu_mail_full)
);

// File: tb/test_dual_mailbox.sv
`timescale 1ns/1ps
module test_dual_mailbox;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  dsp_addr = '0;
   logic        dsp_wr = 1'b0, dsp_rd = 1'b0;
   logic [15:0] dsp_wdata = '0;
   logic [15:0] dsp_rdata;
   logic [1:0]  host_addr = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        dma_start, dsp_mail_full, cpu_mail_full;

   always #2.5 clk = ~clk;

   dual_mailbox i_dual_mailbox (
      .clk (clk), .rst_n (rst_n),
      .dsp_addr (dsp_addr), .dsp_wr (dsp_wr), .dsp_rd (dsp_rd),
      .dsp_wdata (dsp_wdata), .dsp_rdata (dsp_rdata),
      .host_addr (host_addr), .host_wr (host_wr), .host_rd (host_rd),
      .host_wdata (host_wdata), .host_rdata (host_rdata),
      .dma_start (dma_start), .dsp_mail_full (dsp_mail_full),
      .cpu_mail_full (cpu_mail_full)
   );

   // behavioural model: index 0 = mail from DSP, 1 = mail from CPU
   logic [14:0] m_hi [2];
   logic [15:0] m_lo [2];
   bit          m_flag [2];
   logic [15:0] m_gen [256];
   bit          m_dma;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   function automatic logic [15:0] box_read(int m, bit lo);
      return lo ? m_lo[m] : {m_flag[m], m_hi[m]};
   endfunction

   function automatic logic [15:0] exp_dsp_read(logic [7:0] a);
      if (a[7:2] == 6'h3F) return box_read(int'(a[1]), a[0]);
      return m_gen[a];
   endfunction

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_update();
      bit clr [2];
      bit set [2];
      clr[0] = 0; clr[1] = 0; set[0] = 0; set[1] = 0;
      // host first, DSP afterwards so DSP data wins (R7)
      if (host_wr) begin
         if (host_addr[0]) begin m_lo[host_addr[1]] = host_wdata; set[host_addr[1]] = 1; end
         else m_hi[host_addr[1]] = host_wdata[14:0];
      end
      if (host_rd && host_addr[0]) clr[host_addr[1]] = 1;
      m_dma = 0;
      if (dsp_addr[7:2] == 6'h3F) begin
         if (dsp_wr) begin
            if (dsp_addr[0]) begin m_lo[dsp_addr[1]] = dsp_wdata; set[dsp_addr[1]] = 1; end
            else m_hi[dsp_addr[1]] = dsp_wdata[14:0];
         end
         if (dsp_rd && dsp_addr[0]) clr[dsp_addr[1]] = 1;
      end else if (dsp_wr) begin
         m_gen[dsp_addr] = dsp_wdata;
         m_dma = (dsp_addr == 8'hCB);
      end
      for (int m = 0; m < 2; m++) begin
         if (set[m]) m_flag[m] = 1;
         else if (clr[m]) m_flag[m] = 0;
      end
   endtask

   task automatic step(string tag, bit dwr, bit drd, logic [7:0] da, logic [15:0] dwd,
                       bit hwr, bit hrd, logic [1:0] ha, logic [15:0] hwd);
      @(negedge clk);
      // results of the previous edge
      chk(tag, "dsp_mail_full", {15'd0, dsp_mail_full}, {15'd0, m_flag[0]});
      chk(tag, "cpu_mail_full", {15'd0, cpu_mail_full}, {15'd0, m_flag[1]});
      chk(tag, "dma_start",     {15'd0, dma_start},     {15'd0, m_dma});
      dsp_wr = dwr; dsp_rd = drd; dsp_addr = da; dsp_wdata = dwd;
      host_wr = hwr; host_rd = hrd; host_addr = ha; host_wdata = hwd;
      #1;
      chk(tag, "dsp_rdata",  dsp_rdata,  exp_dsp_read(da));
      chk(tag, "host_rdata", host_rdata, box_read(int'(ha[1]), ha[0]));
      @(posedge clk);
      model_update();
   endtask

   initial begin
      for (int m = 0; m < 2; m++) begin m_hi[m] = '0; m_lo[m] = '0; m_flag[m] = 0; end
      for (int i = 0; i < 256; i++) m_gen[i] = '0;
      m_dma = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values
      step("R1", 0, 0, 8'hFC, 16'h0, 0, 0, 2'd3, 16'h0);
      step("R1", 0, 0, 8'h10, 16'h0, 0, 0, 2'd2, 16'h0);
      step("R1", 0, 0, 8'hFF, 16'h0, 0, 0, 2'd1, 16'h0);
      // R2 DSP fills its mailbox
      step("R2", 1, 0, 8'hFC, 16'h1234, 0, 0, 2'd0, 16'h0);
      step("R2", 1, 0, 8'hFD, 16'hBEEF, 0, 0, 2'd0, 16'h0);
      step("R10", 0, 1, 8'hFC, 16'h0, 0, 1, 2'd0, 16'h0);
      // R4 host drains, high read does not clear
      step("R4", 0, 0, 8'hFC, 16'h0, 0, 1, 2'd1, 16'h0);
      step("R4", 0, 0, 8'hFC, 16'h0, 0, 0, 2'd0, 16'h0);
      // R3 high write alone, flag clear then set
      step("R3", 0, 0, 8'hFE, 16'h0, 1, 0, 2'd2, 16'hFFFF);
      step("R5", 0, 0, 8'hFE, 16'h0, 1, 0, 2'd3, 16'h5555);
      step("R3", 0, 0, 8'hFE, 16'h0, 1, 0, 2'd2, 16'h0ACE);
      // R5 DSP side reaches CPU mailbox
      step("R5", 0, 1, 8'hFF, 16'h0, 0, 0, 2'd2, 16'h0);
      step("R5", 1, 0, 8'hFF, 16'h7777, 0, 0, 2'd3, 16'h0);
      step("R5", 0, 1, 8'hFE, 16'h0, 0, 0, 2'd3, 16'h0);
      // R6 write and read of the same low half together
      step("R6", 0, 1, 8'hFF, 16'h0, 1, 0, 2'd3, 16'h0001);
      step("R6", 0, 1, 8'hFF, 16'h0, 0, 0, 2'd3, 16'h0);
      step("R6", 1, 0, 8'hFD, 16'h2222, 0, 1, 2'd1, 16'h0);
      // R7 both sides write the same half
      step("R7", 1, 0, 8'hFD, 16'hAAAA, 1, 0, 2'd1, 16'hBBBB);
      step("R7", 1, 0, 8'hFC, 16'h0123, 1, 0, 2'd0, 16'h4567);
      step("R7", 0, 0, 8'hFD, 16'h0, 0, 0, 2'd0, 16'h0);
      // R8 DMA strobe
      step("R8", 1, 0, 8'hCB, 16'h00C3, 0, 0, 2'd0, 16'h0);
      step("R8", 0, 0, 8'hCB, 16'h0, 0, 0, 2'd0, 16'h0);
      step("R8", 1, 0, 8'hCB, 16'h0011, 0, 0, 2'd0, 16'h0);
      step("R8", 1, 0, 8'hCB, 16'h0022, 0, 0, 2'd0, 16'h0);
      step("R8", 0, 0, 8'hCB, 16'h0, 0, 0, 2'd0, 16'h0);
      // R9 generic file, mailboxes untouched
      step("R9", 1, 0, 8'h10, 16'h4321, 0, 0, 2'd1, 16'h0);
      step("R9", 1, 1, 8'hA0, 16'h9876, 0, 0, 2'd0, 16'h0);
      step("R9", 0, 0, 8'h10, 16'h0, 0, 0, 2'd3, 16'h0);
      step("R9", 0, 0, 8'hA0, 16'h0, 0, 0, 2'd2, 16'h0);
      step("R9", 0, 0, 8'hFD, 16'h0, 0, 0, 2'd0, 16'h0);
      step("R10", 0, 0, 8'hFC, 16'h0, 0, 0, 2'd2, 16'h0);
      step("R10", 0, 0, 8'hFE, 16'h0, 0, 0, 2'd0, 16'h0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule